// File: doc/BRIEF.md
# Boundary-Aware Incrementing Burst Splitter

This block turns a simple burst request (start address, beat count, transfer size, direction) into a beat-by-beat stream of AHB-Lite address-phase signals. Consecutive beats advance by the transfer size in bytes. The block guarantees that no burst it issues ever straddles an address aligned to a configurable boundary, 1 KB by default. When the requested run would reach such an address, the current burst ends on the last beat below the boundary. A fresh burst then opens exactly at the boundary. A slave selected by the address decoder therefore always sees a burst that opens with a NONSEQ transfer and that carries no more beats than its burst code promised.

The burst code is chosen per fragment. A fixed-length incrementing code (4, 8 or 16 beats) is used only when the fragment holds exactly that many beats. A single-beat fragment is marked SINGLE, and any other length is signalled as an undefined-length incrementing burst. The stream stalls whenever HREADY is low. A one-cycle completion pulse follows the acceptance of the final beat. Requests with an unusable size, a zero beat count or a start address not aligned to the size are refused with a one-cycle error pulse, and no transfer is issued for them.

Top module: `ahb_burst_splitter`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), done and err are low and req_ready is high.
- R2: The first beat of a request is driven in the cycle after the request is taken, at haddr equal to req_addr and with htrans NONSEQ (2'b10). Between requests htrans is IDLE, and an IDLE cycle is never followed directly by SEQ (2'b11).
- R3: Each accepted beat is followed by a beat whose address is 2^hsize bytes higher. hsize and hwrite equal the request's size and direction on every beat.
- R4: No burst has beats on both sides of a BOUNDARY-aligned address. Every beat whose address is a multiple of BOUNDARY starts a new burst with htrans NONSEQ.
- R5: A fragment holds min((BOUNDARY - addr mod BOUNDARY) >> size, beats still to issue) beats: one NONSEQ beat followed by SEQ beats. The total number of beats equals req_beats.
- R6: hburst is constant within a fragment. It is INCR4 (3'b011), INCR8 (3'b101) or INCR16 (3'b111) when the fragment holds exactly 4, 8 or 16 beats, SINGLE (3'b000) for one beat, and INCR (3'b001) otherwise.
- R7: While hready is low during a burst, haddr, htrans, hburst, hsize and hwrite keep their values, and the beat is not counted.
- R8: done is high for exactly one cycle. That cycle is the one after the edge that accepts the last beat, and in it htrans is already IDLE.
- R9: A request whose size exceeds MAX_SIZE, whose beat count is zero, or whose address is not a multiple of 2^size raises err for one cycle in the next cycle. htrans stays IDLE.
- R10: req_ready is high only when no request is in progress. req_valid is ignored while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Start byte address |
| req_beats | input | CW | Number of beats, 1 or more |
| req_size | input | 3 | Log2 of bytes per beat |
| req_write | input | 1 | Direction of the whole request |
| hready | input | 1 | Address phase accepted at this edge when high |
| haddr | output | AW | Beat address |
| htrans | output | 2 | Transfer type: IDLE, NONSEQ or SEQ |
| hburst | output | 3 | Burst code of the current fragment |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| done | output | 1 | One-cycle pulse after the last beat is accepted |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong remaining-beat counter shows at once as an htrans value out of place: an early or late NONSEQ, a SEQ beat at a boundary address, or a done pulse one beat early or late. A wrong fragment length also corrupts hburst at the very first beat of that fragment. The sweep covers three sizes, start points placed just below and exactly on a boundary, and beat counts around 4, 8 and 16 as well as counts that span several boundaries. It runs both with hready always high and with stalls, so a counter that advances during a stall shows up within one beat as a moved address.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'b000,
        BU_INCR   = 3'b001,
        BU_WRAP4  = 3'b010,
        BU_INCR4  = 3'b011,
        BU_WRAP8  = 3'b100,
        BU_INCR8  = 3'b101,
        BU_WRAP16 = 3'b110,
        BU_INCR16 = 3'b111
    } hburst_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

endpackage

// File: rtl/bsplit_req_check.sv
// Decides whether a request can be issued: size within bus width,
// non-zero beat count, start address aligned to the transfer size.
module bsplit_req_check #(
    parameter int CW       = 8,
    parameter int MAX_SIZE = 2
) (
    input  logic [6:0]    addr_low,
    input  logic [2:0]    size,
    input  logic [CW-1:0] beats,
    output logic          ok
);
    logic [7:0] mask;
    logic       aligned;
    logic       size_ok;

    always_comb begin
        mask    = (8'd1 << size) - 8'd1;
        aligned = ((addr_low & mask[6:0]) == 7'd0);
        size_ok = ({29'd0, size} <= 32'(MAX_SIZE));
        ok      = size_ok && aligned && (beats != '0);
    end
endmodule

// File: rtl/bsplit_frag_calc.sv
// Length of the fragment that starts at a given offset: beats that fit
// before the next boundary, capped by the beats still to issue.
module bsplit_frag_calc #(
    parameter int BOUNDARY = 1024,
    parameter int CW       = 8
) (
    input  logic [$clog2(BOUNDARY)-1:0] offset,
    input  logic [2:0]                  size,
    input  logic [CW-1:0]               remain,
    output logic [CW-1:0]               len
);
    localparam int OW = $clog2(BOUNDARY);
    localparam int LW = (OW + 1 > CW) ? OW + 1 : CW;

    logic [OW:0]   room;
    logic [LW-1:0] room_x;
    logic [LW-1:0] remain_x;

    always_comb begin
        room     = ((OW + 1)'(BOUNDARY) - {1'b0, offset}) >> size;
        room_x   = LW'(room);
        remain_x = LW'(remain);
        len      = (room_x < remain_x) ? CW'(room_x) : remain;
    end
endmodule

// File: rtl/bsplit_burst_enc.sv
// Maps a fragment length to a burst code. USE_FIXED selects whether
// exact 4/8/16-beat fragments get their fixed-length code.
module bsplit_burst_enc
    import bsplit_pkg::*;
#(
    parameter int CW        = 8,
    parameter bit USE_FIXED = 1'b1
) (
    input  logic [CW-1:0] len,
    output hburst_e       code
);
    logic [31:0] len_w;
    assign len_w = 32'(len);

    generate
        if (USE_FIXED) begin : g_fixed
            always_comb begin
                unique case (len_w)
                    32'd1:   code = BU_SINGLE;
                    32'd4:   code = BU_INCR4;
                    32'd8:   code = BU_INCR8;
                    32'd16:  code = BU_INCR16;
                    default: code = BU_INCR;
                endcase
            end
        end else begin : g_open
            always_comb begin
                code = (len_w == 32'd1) ? BU_SINGLE : BU_INCR;
            end
        end
    endgenerate
endmodule

// File: rtl/ahb_burst_splitter.sv
module ahb_burst_splitter
    import bsplit_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 8,
    parameter int BOUNDARY  = 1024,
    parameter int MAX_SIZE  = 2,
    parameter bit USE_FIXED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_beats,
    input  logic [2:0]    req_size,
    input  logic          req_write,
    input  logic          hready,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    output logic [2:0]    hsize,
    output logic          hwrite,
    output logic          done,
    output logic          err
);
    localparam int OW = $clog2(BOUNDARY);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
        logic [CW-1:0] frag;
        logic [2:0]    size;
        logic          write;
        htrans_e       trans;
        hburst_e       burst;
        logic          done;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] step_addr;
    logic [AW-1:0] calc_addr;
    logic [CW-1:0] calc_rem;
    logic [2:0]    calc_size;
    logic [CW-1:0] frag_len;
    hburst_e       frag_code;
    logic          req_ok;

    assign step_addr = r_q.addr + (AW'(1) << r_q.size);
    assign calc_addr = (r_q.st == ST_RUN) ? step_addr : req_addr;
    assign calc_rem  = (r_q.st == ST_RUN) ? (r_q.rem - CW'(1)) : req_beats;
    assign calc_size = (r_q.st == ST_RUN) ? r_q.size : req_size;

    bsplit_req_check #(.CW(CW), .MAX_SIZE(MAX_SIZE)) u_check (
        .addr_low (req_addr[6:0]),
        .size     (req_size),
        .beats    (req_beats),
        .ok       (req_ok)
    );

    bsplit_frag_calc #(.BOUNDARY(BOUNDARY), .CW(CW)) u_frag (
        .offset (calc_addr[OW-1:0]),
        .size   (calc_size),
        .remain (calc_rem),
        .len    (frag_len)
    );

    bsplit_burst_enc #(.CW(CW), .USE_FIXED(USE_FIXED)) u_enc (
        .len  (frag_len),
        .code (frag_code)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_ok) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st    = ST_RUN;
                        r_d.addr  = req_addr;
                        r_d.rem   = req_beats;
                        r_d.size  = req_size;
                        r_d.write = req_write;
                        r_d.frag  = frag_len;
                        r_d.trans = TR_NONSEQ;
                        r_d.burst = frag_code;
                    end
                end
            end
            ST_RUN: begin
                if (hready) begin
                    if (r_q.rem == CW'(1)) begin
                        r_d.st    = ST_IDLE;
                        r_d.trans = TR_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr = step_addr;
                        r_d.rem  = r_q.rem - CW'(1);
                        if (r_q.frag == CW'(1)) begin
                            r_d.frag  = frag_len;
                            r_d.trans = TR_NONSEQ;
                            r_d.burst = frag_code;
                        end else begin
                            r_d.frag  = r_q.frag - CW'(1);
                            r_d.trans = TR_SEQ;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign haddr     = r_q.addr;
    assign htrans    = r_q.trans;
    assign hburst    = r_q.burst;
    assign hsize     = r_q.size;
    assign hwrite    = r_q.write;
    assign done      = r_q.done;
    assign err       = r_q.err;

    // Stalled address phase must not move.
    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && !hready) |=>
            ($stable(haddr) && $stable(htrans) && $stable(hburst)
             && $stable(hsize) && $stable(hwrite)));

    // A SEQ beat sits one transfer size above the beat accepted before it.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && hready) |=>
            (htrans != 2'b11 || haddr == $past(haddr) + (AW'(1) << $past(hsize))));

    // No SEQ beat lands on a boundary address.
    assert_no_seq_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> (haddr[OW-1:0] != '0));

    // After IDLE a burst can only open with NONSEQ.
    assert_idle_then_nonseq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b00) |=> (htrans != 2'b11));

    // A fragment never promises more beats than remain.
    assert_frag_le_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10) |-> (r_q.frag != '0 && r_q.frag <= r_q.rem));

    // A fixed-length code matches the fragment it opens.
    assert_incr4_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10 && hburst == 3'b011) |-> (r_q.frag == CW'(4)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_no_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (htrans == 2'b00 && !done));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (htrans == 2'b00));

endmodule

// File: tb/ahb_burst_splitter_bench.sv
module ahb_burst_splitter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int CW = 6;
    localparam int BND = 64;
    localparam int MAXS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_beats = '0;
    logic [2:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic          hready = 1'b1;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic [2:0]    hburst;
    logic [2:0]    hsize;
    logic          hwrite;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ahb_burst_splitter #(
        .AW(AW), .CW(CW), .BOUNDARY(BND), .MAX_SIZE(MAXS), .USE_FIXED(1'b1)
    ) u_ahb_burst_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_beats(req_beats),
        .req_size(req_size), .req_write(req_write),
        .hready(hready), .haddr(haddr), .htrans(htrans),
        .hburst(hburst), .hsize(hsize), .hwrite(hwrite),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int code_for(input int len);
        if (len == 1) return 0;
        if (len == 4) return 3;
        if (len == 8) return 5;
        if (len == 16) return 7;
        return 1;
    endfunction

    function automatic bit next_stall();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return stall_mode && (lfsr[1:0] == 2'b00);
    endfunction

    task automatic run_req(input int a, input int sz, input int nb, input bit wr, input bit poke);
        int e_addr, e_rem, e_fl, e_code, step, room, guard, prev_addr;
        bit first_req, first_frag, was_stalled;
        step = 1 << sz;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", req_ready, 1);
        req_valid = 1'b1; req_addr = AW'(a); req_size = 3'(sz);
        req_beats = CW'(nb); req_write = wr;
        @(negedge clk);
        // poke: a refused-looking request held during the burst must be ignored
        req_valid = poke; req_addr = AW'(a + 1); req_size = 3'd3; req_beats = '0;
        e_addr = a; e_rem = nb; e_fl = 0; e_code = 0;
        first_req = 1'b1; first_frag = 1'b0; was_stalled = 1'b0; prev_addr = 0;
        guard = 0;
        while (e_rem > 0 && guard < 2000) begin
            guard++;
            if (e_fl == 0) begin
                room = (BND - (e_addr % BND)) >> sz;
                e_fl = (room < e_rem) ? room : e_rem;
                e_code = code_for(e_fl);
                first_frag = 1'b1;
            end
            if (was_stalled)
                chk(haddr == AW'(prev_addr), "R7", haddr, prev_addr);
            if (first_req)
                chk(htrans == 2'b10, "R2", htrans, 2);
            else if (first_frag && (e_addr % BND) == 0)
                chk(htrans == 2'b10, "R4", htrans, 2);
            else if (first_frag)
                chk(htrans == 2'b10, "R5", htrans, 2);
            else
                chk(htrans == 2'b11, "R5", htrans, 3);
            chk(haddr == AW'(e_addr), "R3", haddr, e_addr);
            chk(hburst == 3'(e_code), "R6", hburst, e_code);
            chk(hsize == 3'(sz) && hwrite == wr, "R3", {hsize, hwrite}, {sz[2:0], wr});
            chk(done == 1'b0 && err == 1'b0, "R10", {done, err}, 0);
            chk(req_ready == 1'b0, "R10", req_ready, 0);
            hready = !next_stall();
            prev_addr = e_addr;
            was_stalled = !hready;
            if (hready) begin
                e_addr += step; e_rem--; e_fl--;
                first_req = 1'b0; first_frag = 1'b0;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        hready = 1'b1;
        chk(done == 1'b1, "R8", done, 1);
        chk(htrans == 2'b00, "R8", htrans, 0);
        chk(err == 1'b0, "R10", err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", done, 0);
    endtask

    task automatic bad_req(input int a, input int sz, input int nb);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_size = 3'(sz); req_beats = CW'(nb);
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R9", err, 1);
        chk(htrans == 2'b00, "R9", htrans, 0);
        @(negedge clk);
        chk(err == 1'b0, "R9", err, 0);
        chk(htrans == 2'b00 && req_ready == 1'b1, "R9", {htrans, req_ready}, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int offs[10];
        int lens[11];
        offs = '{0, 1, 2, 3, 4, 5, 8, 15, 16, 17};
        lens = '{1, 2, 3, 4, 5, 8, 9, 16, 17, 20, 33};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(htrans == 2'b00, "R1", htrans, 0);
        chk(done == 1'b0 && err == 1'b0, "R1", {done, err}, 0);
        chk(req_ready == 1'b1, "R1", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(htrans == 2'b00 && req_ready == 1'b1, "R1", {htrans, req_ready}, 1);

        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);
            for (int sz = 0; sz <= MAXS; sz++)
                for (int oi = 0; oi < 10; oi++)
                    for (int li = 0; li < 11; li++)
                        run_req(2 * BND - offs[oi] * (1 << sz), sz, lens[li],
                                bit'((oi + li) & 1), bit'(li == 10));
        end

        bad_req(1, 1, 4);
        bad_req(6, 2, 4);
        bad_req(0, 3, 4);
        bad_req(8, 0, 0);
        run_req(0, 2, 16, 1'b0, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule